// File: doc/BRIEF.md
# Idle-Column Deleting Elastic Buffer

This block moves a stream of four-byte lane columns from a write clock into a read clock that may run slightly slower, by up to 200 ppm. Each column holds 32 data bits, 4 control bits and a 3-bit type tag. The tag codes are: data = 0, start = 1, terminate = 2, plain idle = 3, discardable idle = 4. The column order is preserved. Columns are never split, so rate matching only ever removes a whole column.

Drift builds up slowly, at under 3 bits per maximum-length packet. When the write-side fill level reaches a programmable high-water mark, the buffer raises a deletion request. The request removes exactly one discardable idle column. That column must also leave the current inter-packet gap at or above `MIN_GAP` columns; the terminate column counts as the first gap column. If the current gap offers no such column, the request stays pending into later packets. One removed column absorbs the drift of about a dozen packets.

Pointers cross between the clocks in Gray code through two-flop synchronizers. The fill level is computed in the write clock. A deletion is carried out by not writing the chosen column. The parameter `N_UPSTREAM` counts the non-synchronous stages upstream of this buffer. The mark is capped so that `N_UPSTREAM + 1` columns of room remain above it, which covers the wait of that many gaps for a deletion chance.

Back-pressure rules: the writer is a line-rate source and cannot stall. `in_ready` is low while the buffer is full, but a column presented then is dropped and flagged, not held. On the read side `out_valid` is high whenever the read clock is out of reset. An `out_valid && out_ready` handshake consumes the head column. When the buffer is empty it presents a filler idle column instead, and the handshake then marks an underflow.

Top module: `eb_idle_drop_fifo`

## Requirements
- R1: After reset, `fill` is 0, `del_pending`, `overflow` and `underflow` are 0, `in_ready` is 1, and once the read clock leaves reset `out_valid` is 1 and the output shows the filler idle column.
- R2: Every column that is not deleted leaves the read side whole (data, control and tag unchanged) and in the order it was written.
- R3: Only columns tagged 4 (discardable idle) may be deleted. Columns tagged 0, 1, 2 or 3 always pass, even while a request is pending.
- R4: `del_pending` goes high the cycle after `fill` is at or above the effective mark. Each request deletes exactly one column and then clears. It is raised again only if `fill` is still at or above the mark.
- R5: A pending request deletes a tag-4 column only if at least `MIN_GAP` columns of the current gap have already passed (terminate column included). Otherwise the request stays pending across later packets.
- R6: The effective mark is the smaller of `hwm` and `2**AW - (N_UPSTREAM + 1)`.
- R7: A column written while `fill` equals `2**AW` is dropped and sets the sticky `overflow` flag. `in_ready` is low while full, and `fill` never exceeds `2**AW`.
- R8: A read handshake while empty consumes nothing and sets the sticky `underflow` flag. The filler column shown while empty is data 32'h07070707, control 4'hF, tag 3.
- R9: After the buffer is drained, `fill` returns to 0 within a few write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write clock |
| in_valid | input | 1 | A column is presented this cycle |
| in_ready | output | 1 | Buffer not full (advisory; the writer cannot stall) |
| in_data | input | 32 | Column data bytes |
| in_ctl | input | 4 | Per-byte control bits |
| in_tag | input | 3 | Column type tag |
| hwm | input | AW+1 | Programmable high-water mark in columns |
| fill | output | AW+1 | Write-side fill level in columns |
| del_pending | output | 1 | Deletion request pending |
| overflow | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read clock |
| out_valid | output | 1 | An output column is presented |
| out_ready | input | 1 | Consumer takes the presented column |
| out_data | output | 32 | Output column data |
| out_ctl | output | 4 | Output column control bits |
| out_tag | output | 3 | Output column tag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The stream is tried with the mark above the fill level, so that nothing may vanish. It is also tried with a low mark, where one discardable idle is removed from a three-column gap. A sequence with two-column gaps and all-plain-idle gaps shows that the request waits through packets until a long enough gap arrives. A high `hwm` against a long data burst separates the capped mark from the raw mark. A burst past capacity shows which column is lost on overflow. Draining each sequence exposes reordering, and draining past the end exposes the filler and underflow behaviour.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic [2:0] {
    COL_DATA  = 3'd0,
    COL_START = 3'd1,
    COL_TERM  = 3'd2,
    COL_IDLE  = 3'd3,
    COL_RIDLE = 3'd4
  } col_tag_e;

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  ctl;
    col_tag_e    tag;
  } col_t;

  localparam int COL_W = $bits(col_t);

  function automatic col_t filler_col();
    col_t c;
    c.data = 32'h0707_0707;
    c.ctl  = 4'hF;
    c.tag  = COL_IDLE;
    return c;
  endfunction
endpackage

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eb_store.sv
module eb_store #(
  parameter int AW = 4,
  parameter int W  = 39
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl
  import eb_pkg::*;
#(
  parameter int AW         = 4,
  parameter int MIN_GAP    = 2,
  parameter int N_UPSTREAM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  col_tag_e      in_tag,
  input  logic [AW:0]   hwm,
  input  logic [AW:0]   rd_gray_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_gray,
  output logic [AW:0]   fill,
  output logic          in_ready,
  output logic          del_pending,
  output logic          overflow,
  output logic          col_drop
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int GW    = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);
  localparam logic [PW-1:0] CAP_V  = PW'(DEPTH - (N_UPSTREAM + 1));
  localparam logic [PW-1:0] FULL_V = PW'(DEPTH);
  localparam logic [GW-1:0] GAP_V  = GW'(MIN_GAP);

  logic [PW-1:0] wbin, rbin_s, mark;
  logic [GW-1:0] gap_cnt;
  logic          full, eligible, passed;

  always_comb begin
    rbin_s[PW-1] = rd_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rd_gray_s[i];
  end

  assign fill     = wbin - rbin_s;
  assign full     = (fill == FULL_V);
  assign in_ready = !full;
  assign mark     = (hwm > CAP_V) ? CAP_V : hwm;
  assign eligible = (in_tag == COL_RIDLE) && (gap_cnt >= GAP_V);
  assign col_drop = in_valid && del_pending && eligible;
  assign passed   = in_valid && !col_drop;
  assign wr_en    = passed && !full;
  assign wr_addr  = wbin[AW-1:0];
  assign wr_gray  = wbin ^ (wbin >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin        <= '0;
      del_pending <= 1'b0;
      overflow    <= 1'b0;
      gap_cnt     <= GAP_V;
    end else begin
      wbin <= wbin + PW'(wr_en);
      if (del_pending) del_pending <= !col_drop;
      else             del_pending <= (fill >= mark);
      if (passed && full) overflow <= 1'b1;
      if (passed) begin
        case (in_tag)
          COL_TERM:            gap_cnt <= GW'(1);
          COL_IDLE, COL_RIDLE: if (gap_cnt < GAP_V) gap_cnt <= gap_cnt + GW'(1);
          default:             gap_cnt <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic [AW:0]   wr_gray_s,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rd_gray,
  output logic          empty,
  output logic          out_valid,
  output logic          underflow
);
  localparam int PW = AW + 1;
  logic [PW-1:0] rbin;
  logic          take;

  assign rd_gray = rbin ^ (rbin >> 1);
  assign empty   = (rd_gray == wr_gray_s);
  assign take    = out_valid && out_ready && !empty;
  assign rd_addr = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      out_valid <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      rbin      <= rbin + PW'(take);
      if (out_valid && out_ready && empty) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/eb_idle_drop_fifo.sv
module eb_idle_drop_fifo
  import eb_pkg::*;
#(
  parameter int AW         = 4,
  parameter int MIN_GAP    = 2,
  parameter int N_UPSTREAM = 2
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_ctl,
  input  logic [2:0]  in_tag,
  input  logic [AW:0] hwm,
  output logic [AW:0] fill,
  output logic        del_pending,
  output logic        overflow,
  input  logic        rd_clk,
  input  logic        rd_rst_n,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_ctl,
  output logic [2:0]  out_tag,
  output logic        underflow
);
  logic          wr_en, col_drop, empty;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  col_t          in_col, head_col, out_col;

  assign in_col.data = in_data;
  assign in_col.ctl  = in_ctl;
  assign in_col.tag  = col_tag_e'(in_tag);

  eb_wr_ctrl #(.AW(AW), .MIN_GAP(MIN_GAP), .N_UPSTREAM(N_UPSTREAM)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_tag(in_col.tag),
    .hwm(hwm), .rd_gray_s(rd_gray_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_gray(wr_gray), .fill(fill), .in_ready(in_ready),
    .del_pending(del_pending), .overflow(overflow), .col_drop(col_drop)
  );

  eb_gray_sync #(.W(AW + 1)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  eb_gray_sync #(.W(AW + 1)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  eb_store #(.AW(AW), .W(COL_W)) u_store (
    .wr_clk(wr_clk), .we(wr_en), .waddr(wr_addr), .wdata(in_col),
    .raddr(rd_addr), .rdata(head_col)
  );

  eb_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .out_ready(out_ready),
    .wr_gray_s(wr_gray_s), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .empty(empty), .out_valid(out_valid), .underflow(underflow)
  );

  assign out_col  = empty ? filler_col() : head_col;
  assign out_data = out_col.data;
  assign out_ctl  = out_col.ctl;
  assign out_tag  = out_col.tag;
endmodule

// File: rtl/eb_idle_drop_fifo_chk.sv
module eb_idle_drop_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wr_clk,
  input logic        wr_rst_n,
  input logic        rd_clk,
  input logic        rd_rst_n,
  input logic        in_valid,
  input logic [2:0]  in_tag,
  input logic [AW:0] fill,
  input logic        del_pending,
  input logic        overflow,
  input logic        col_drop,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_tag,
  input logic        underflow
);
  localparam logic [AW:0] FULL_V = (AW + 1)'(1 << AW);

  a_r7_fill_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    fill <= FULL_V);
  a_r7_ovf_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(overflow) |-> $past(in_valid && fill == FULL_V));
  a_r7_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    overflow |=> overflow);
  a_r3_drop_only_ridle: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    col_drop |-> (in_valid && in_tag == 3'd4 && del_pending));
  a_r4_one_per_request: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    col_drop |=> !del_pending);
  a_r8_unf_cause: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(underflow) |-> $past(out_valid && out_ready && out_tag == 3'd3));
  a_r8_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    underflow |=> underflow);
endmodule

bind eb_idle_drop_fifo eb_idle_drop_fifo_chk #(.AW(AW)) u_chk (.*);

// File: tb/eb_idle_drop_fifo_tb.sv
module eb_idle_drop_fifo_tb;
  localparam int AW = 4;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n, rd_rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;
  logic [3:0]  in_ctl, out_ctl;
  logic [2:0]  in_tag, out_tag;
  logic [AW:0] hwm, fill;
  logic        del_pending, overflow, underflow;

  int n_chk = 0, n_err = 0;
  logic [38:0] expq [0:31];
  int nexp;

  always #2.5 wr_clk = ~wr_clk;
  always #3   rd_clk = ~rd_clk;

  eb_idle_drop_fifo #(.AW(AW), .MIN_GAP(2), .N_UPSTREAM(2)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctl(in_ctl), .in_tag(in_tag), .hwm(hwm), .fill(fill),
    .del_pending(del_pending), .overflow(overflow), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctl(out_ctl), .out_tag(out_tag), .underflow(underflow)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [AW:0] mark);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; hwm = mark;
    in_data = '0; in_ctl = '0; in_tag = '0;
    nexp = 0;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (3) @(negedge wr_clk);
  endtask

  // tag: 0 data, 1 start, 2 terminate, 3 idle, 4 discardable idle
  task automatic push(input logic [2:0] tag, input int idx, input bit keep);
    logic [3:0] c;
    c = (tag == 3'd0) ? 4'h0 : (tag == 3'd1) ? 4'h1 : 4'hF;
    in_valid = 1'b1;
    in_tag   = tag;
    in_ctl   = c;
    in_data  = {8'(tag), 8'hA5, 16'(idx)};
    if (keep) begin
      expq[nexp] = {in_data, c, tag};
      nexp++;
    end
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    in_valid = 1'b0;
    repeat (6) @(negedge rd_clk);
    for (int i = 0; i < nexp; i++) begin
      chk(out_valid && {out_data, out_ctl, out_tag} == expq[i], req,
          {25'd0, out_data, out_ctl, out_tag}, {25'd0, expq[i]});
      out_ready = 1'b1;
      @(negedge rd_clk);
    end
    chk({out_data, out_ctl, out_tag} == {32'h07070707, 4'hF, 3'd3}, "R8 filler column",
        {out_data, out_ctl, out_tag}, {32'h07070707, 4'hF, 3'd3});
    chk(underflow == 1'b0, "R8 no underflow before empty read", underflow, 0);
    @(negedge rd_clk);
    out_ready = 1'b0;
    chk(underflow == 1'b1, "R8 underflow on empty read", underflow, 1);
    repeat (6) @(negedge wr_clk);
    chk(fill == 0, "R9 fill back to zero", fill, 0);
  endtask

  task automatic t_reset();
    do_reset(5'd16);
    chk(fill == 0, "R1 fill", fill, 0);
    chk(!del_pending && !overflow && !underflow, "R1 flags",
        {del_pending, overflow, underflow}, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid && out_tag == 3'd3 && out_data == 32'h07070707, "R1 output idle",
        {out_valid, out_tag}, {1'b1, 3'd3});
  endtask

  task automatic t_pass();
    do_reset(5'd16);
    push(1, 0, 1); push(0, 1, 1); push(0, 2, 1); push(2, 3, 1);
    push(3, 4, 1); push(4, 5, 1); push(4, 6, 1); push(1, 7, 1); push(0, 8, 1);
    chk(fill == 9, "R2 nothing deleted below mark", fill, 9);
    chk(!del_pending, "R4 no request below mark", del_pending, 0);
    drain("R2 order preserved");
  endtask

  task automatic t_delete();
    do_reset(5'd4);
    push(1, 0, 1); push(0, 1, 1); push(0, 2, 1); push(0, 3, 1);
    chk(!del_pending, "R4 request not yet raised", del_pending, 0);
    push(2, 4, 1);
    chk(del_pending, "R4 request raised at mark", del_pending, 1);
    push(4, 5, 1);
    push(4, 6, 0);
    chk(!del_pending, "R4 request cleared after one deletion", del_pending, 0);
    push(1, 7, 1); push(0, 8, 1);
    chk(fill == 8, "R4 exactly one column deleted", fill, 8);
    chk(del_pending, "R4 request raised again above mark", del_pending, 1);
    drain("R3 discardable idle removed");
  endtask

  task automatic t_wait();
    do_reset(5'd2);
    push(1, 0, 1); push(0, 1, 1); push(2, 2, 1);
    push(4, 3, 1);
    push(1, 4, 1); push(0, 5, 1); push(2, 6, 1);
    push(3, 7, 1); push(3, 8, 1); push(3, 9, 1);
    push(1, 10, 1); push(0, 11, 1);
    chk(del_pending, "R5 request pending across packets", del_pending, 1);
    chk(fill == 12, "R3 short gap and plain idles kept", fill, 12);
    push(2, 12, 1); push(4, 13, 1); push(4, 14, 0); push(3, 15, 1);
    chk(fill == 15, "R5 deletion in later long gap", fill, 15);
    drain("R5 stream after delayed deletion");
  endtask

  task automatic t_clamp();
    do_reset(5'd20);
    push(1, 0, 1);
    for (int i = 1; i < 13; i++) push(0, i, 1);
    chk(!del_pending, "R6 no request below capped mark", del_pending, 0);
    push(2, 13, 1);
    chk(del_pending, "R6 request at capped mark", del_pending, 1);
    push(4, 14, 1); push(4, 15, 0);
    chk(fill == 15, "R6 deletion under capped mark", fill, 15);
    drain("R6 stream order");
  endtask

  task automatic t_overflow();
    do_reset(5'd20);
    push(1, 0, 1);
    for (int i = 1; i < 16; i++) push(0, i, 1);
    chk(fill == 16 && !in_ready, "R7 full and not ready", {fill, in_ready}, {5'd16, 1'b0});
    chk(!overflow, "R7 no overflow before extra write", overflow, 0);
    push(0, 16, 0);
    chk(overflow, "R7 overflow set", overflow, 1);
    chk(fill == 16, "R7 fill bounded", fill, 16);
    drain("R7 extra column dropped");
    chk(overflow, "R7 overflow sticky", overflow, 1);
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_delete();
    t_wait();
    t_clamp();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule